// File: doc/BRIEF.md
# Time-Triggered CAN Local Time Base

This block holds the local time of a time-triggered CAN controller. A 16-bit counter advances once for each tick of a programmable clock divider. On compare match it can optionally fall back to zero, or it can run freely and wrap. A second output, the cycle time, is the local time minus a reference mark. The mark is latched from the counter on a capture pulse while the controller works in a time-triggered mode. In event-triggered mode the mark is treated as zero, so the cycle time follows the local time exactly.

The block also holds a 6-bit base-cycle counter. A cycle-advance pulse steps it, and it wraps after a programmable maximum. A CPU reaches all three values through a small register bus with a combinational read port. The CPU may write only the local time, and only while the timer is enabled in event-triggered mode. Control bits, the compare value, the divide field, the mode field and the maximum cycle number are plain inputs.

Top module: `ttcan_local_timer`

## Requirements
- R1: After reset the local time, cycle time and base cycle are all 0. While enabled, the local time rises by one on every (N+1)-th clock, where N is the 4-bit divide field.
- R2: While `tmr_en` is 0 the local time reads 0 on `local_time` and on the bus, CPU writes to it are ignored, and the divider restarts. The first increment after enable is visible N+1 clocks after `tmr_en` goes high.
- R3: With `clr_on_match` = 1, a tick that finds the local time equal to `cmp_val` sets it to 0, and counting goes on from there. The count therefore runs 0..cmp_val repeatedly.
- R4: With `clr_on_match` = 0 the local time runs freely and wraps from 0xFFFF to 0x0000.
- R5: A bus write to register select 0 (local time) loads `bus_wdata` on the next edge only when `mode` = 3'b111 (event-triggered). Every other mode value leaves the counter unchanged.
- R6: In modes other than 3'b111, a `ref_capture` pulse latches the current local time as the reference mark. `cycle_time` equals local time minus the mark, modulo 2^16, and register select 1 reads the same value.
- R7: In mode 3'b111 the reference mark is zero and `ref_capture` is ignored, so `cycle_time` equals `local_time`. The mark stays zero after leaving that mode until the next capture.
- R8: While enabled, each clock with `cycle_adv` high steps the base cycle. A step from `max_cycle` gives 0. The base cycle is 0 while the timer is disabled.
- R9: Register select 2 reads the base cycle in bits 5:0 with bits 15:6 zero. Bus writes to select 1 or 2 change no state.
- R10: A permitted CPU write on the same edge as a compare-match clear wins: the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 local time, 1 cycle time, 2 base cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| tmr_en | input | 1 | Timer enable |
| clr_on_match | input | 1 | Clear local time on compare match |
| cmp_val | input | 16 | Compare value |
| mode | input | 3 | Operating mode; 3'b111 = event-triggered |
| presc_div | input | 4 | Divider field, divide by value+1 |
| max_cycle | input | 6 | Last base-cycle number before wrap |
| ref_capture | input | 1 | Reference-mark capture pulse |
| cycle_adv | input | 1 | Base-cycle advance pulse |
| local_time | output | 16 | Local time |
| cycle_time | output | 16 | Local time minus reference mark |
| base_cycle | output | 6 | Current base cycle |

## Verification
Every state change lands on the first clock edge after its cause: a write, a capture, a cycle-advance or a disable takes effect on the edge that samples it. A divider tick is due on the (N+1)-th edge after enable, so after n edges the expected local time is n/(N+1), or n mod (cmp_val+1) with clear on match. The read port and `cycle_time` are combinational. The bench changes inputs just after a falling edge, lets the chosen number of rising edges pass, and compares on the next falling edge. Bus reads are compared one time step after the select settles.

// File: rtl/ttcan_lt_pkg.sv
package ttcan_lt_pkg;

    typedef enum logic [1:0] {
        SEL_LOCAL_TIME = 2'd0,
        SEL_CYCLE_TIME = 2'd1,
        SEL_BASE_CYCLE = 2'd2,
        SEL_UNUSED     = 2'd3
    } lt_reg_sel_e;

    localparam logic [2:0] MODE_EVENT_TRIG = 3'b111;

endpackage

// File: rtl/ttcan_lt_divider.sv
module ttcan_lt_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = en_i && (st_q.phase >= div_i);
        if (!en_i) begin
            st_d.phase = '0;
        end else if (tick_o) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The phase restarts whenever the timer is off
    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o || (div_i == '0)) else $error("divider ticked early"); // R2

endmodule

// File: rtl/ttcan_lt_timebase.sv
module ttcan_lt_timebase #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              clr_match_i,
    input  logic [TIME_W-1:0] cmp_i,
    input  logic              event_mode_i,
    input  logic              wr_i,
    input  logic [TIME_W-1:0] wdata_i,
    input  logic              cap_i,
    output logic [TIME_W-1:0] time_o,
    output logic [TIME_W-1:0] cyc_time_o
);

    typedef struct packed {
        logic [TIME_W-1:0] count;
        logic [TIME_W-1:0] mark;
    } tb_st_t;

    tb_st_t            st_d, st_q;
    logic              wr_ok;
    logic              hit;
    logic [TIME_W-1:0] mark_eff;

    always_comb begin
        st_d  = st_q;
        wr_ok = en_i && wr_i && event_mode_i;
        hit   = clr_match_i && (st_q.count == cmp_i);

        if (!en_i) begin
            st_d.count = '0;
        end else if (wr_ok) begin
            st_d.count = wdata_i;
        end else if (tick_i) begin
            st_d.count = hit ? '0 : st_q.count + 1'b1;
        end

        if (event_mode_i) begin
            st_d.mark = '0;
        end else if (cap_i) begin
            st_d.mark = st_q.count;
        end

        mark_eff   = event_mode_i ? '0 : st_q.mark;
        time_o     = en_i ? st_q.count : '0;
        cyc_time_o = time_o - mark_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> st_q.count == '0) else $error("count not cleared"); // R2
    AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && tick_i && clr_match_i && (st_q.count == cmp_i) && !wr_i |=> st_q.count == '0) else $error("no clear on match"); // R3
    AST_TT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && wr_i && !event_mode_i && !tick_i |=> $stable(st_q.count)) else $error("write in TT mode"); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && wr_i && event_mode_i |=> st_q.count == $past(wdata_i)) else $error("write lost"); // R10
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i && !event_mode_i |=> st_q.mark == $past(st_q.count)) else $error("mark not captured"); // R6

endmodule

// File: rtl/ttcan_lt_cycle.sv
module ttcan_lt_cycle #(
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             adv_i,
    input  logic [CYC_W-1:0] max_i,
    output logic [CYC_W-1:0] cyc_o
);

    typedef struct packed {
        logic [CYC_W-1:0] num;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.num = '0;
        end else if (adv_i) begin
            st_d.num = (st_q.num >= max_i) ? '0 : st_q.num + 1'b1;
        end
        cyc_o = st_q.num;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CYC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && adv_i && (st_q.num == max_i) |=> st_q.num == '0) else $error("cycle did not wrap"); // R8
    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !adv_i |=> $stable(st_q.num)) else $error("cycle moved"); // R8

endmodule

// File: rtl/ttcan_local_timer.sv
module ttcan_local_timer
    import ttcan_lt_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int CYC_W  = 6,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [TIME_W-1:0] bus_wdata,
    output logic [TIME_W-1:0] bus_rdata,
    input  logic              tmr_en,
    input  logic              clr_on_match,
    input  logic [TIME_W-1:0] cmp_val,
    input  logic [2:0]        mode,
    input  logic [DIV_W-1:0]  presc_div,
    input  logic [CYC_W-1:0]  max_cycle,
    input  logic              ref_capture,
    input  logic              cycle_adv,
    output logic [TIME_W-1:0] local_time,
    output logic [TIME_W-1:0] cycle_time,
    output logic [CYC_W-1:0]  base_cycle
);

    localparam int PAD_W = TIME_W - CYC_W;

    logic        tick;
    logic        event_mode;
    logic        time_wr;
    lt_reg_sel_e sel;

    assign sel        = lt_reg_sel_e'(bus_addr);
    assign event_mode = (mode == MODE_EVENT_TRIG);
    assign time_wr    = bus_sel && bus_wr && (sel == SEL_LOCAL_TIME);

    ttcan_lt_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tmr_en),
        .div_i  (presc_div),
        .tick_o (tick)
    );

    ttcan_lt_timebase #(.TIME_W(TIME_W)) u_time (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (tmr_en),
        .tick_i       (tick),
        .clr_match_i  (clr_on_match),
        .cmp_i        (cmp_val),
        .event_mode_i (event_mode),
        .wr_i         (time_wr),
        .wdata_i      (bus_wdata),
        .cap_i        (ref_capture),
        .time_o       (local_time),
        .cyc_time_o   (cycle_time)
    );

    ttcan_lt_cycle #(.CYC_W(CYC_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (tmr_en),
        .adv_i (cycle_adv),
        .max_i (max_cycle),
        .cyc_o (base_cycle)
    );

    always_comb begin
        unique case (sel)
            SEL_LOCAL_TIME: bus_rdata = local_time;
            SEL_CYCLE_TIME: bus_rdata = cycle_time;
            SEL_BASE_CYCLE: bus_rdata = {{PAD_W{1'b0}}, base_cycle};
            default:        bus_rdata = '0;
        endcase
    end

    AST_ET_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        event_mode |-> cycle_time == local_time) else $error("cycle time differs"); // R7

endmodule

// File: tb/ttcan_local_timer_test.sv
`timescale 1ns/1ps
module ttcan_local_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tmr_en = 1'b0, clr_on_match = 1'b0;
    logic [15:0] cmp_val = '0;
    logic [2:0]  mode = 3'd0;
    logic [3:0]  presc_div = '0;
    logic [5:0]  max_cycle = '0;
    logic        ref_capture = 1'b0, cycle_adv = 1'b0;
    logic [15:0] local_time, cycle_time;
    logic [5:0]  base_cycle;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ttcan_local_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_en(tmr_en), .clr_on_match(clr_on_match), .cmp_val(cmp_val),
        .mode(mode), .presc_div(presc_div), .max_cycle(max_cycle),
        .ref_capture(ref_capture), .cycle_adv(cycle_adv),
        .local_time(local_time), .cycle_time(cycle_time), .base_cycle(base_cycle)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic restart();
        tmr_en = 1'b0;
        step(1);
        tmr_en = 1'b1;
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        logic [15:0] held;
        step(2);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        chk("R1 reset local", local_time, 16'h0000);
        chk("R1 reset cycle", cycle_time, 16'h0000);
        chk("R1 reset base", {10'd0, base_cycle}, 16'h0000);

        // R1/R2: divider sweep, count after n edges = n/(N+1)
        for (int dv = 0; dv < 4; dv++) begin
            presc_div = dv[3:0];
            restart();
            for (int n = 1; n <= 12; n++) begin
                step(1);
                chk("R1 divided count", local_time, 16'(n / (dv + 1)));
            end
        end

        // R2: first increment only after N+1 edges
        presc_div = 4'd7;
        restart();
        step(7);
        chk("R2 enable latency before", local_time, 16'd0);
        step(1);
        chk("R2 enable latency after", local_time, 16'd1);

        // R2: disabled -> zero, writes ignored
        tmr_en = 1'b0; mode = 3'b111;
        step(1);
        bus_write(2'd0, 16'h5555);
        chk("R2 disabled port", local_time, 16'h0000);
        bus_read(2'd0, rd);
        chk("R2 disabled bus", rd, 16'h0000);

        // R3: clear on match sweep
        mode = 3'd0; clr_on_match = 1'b1; presc_div = 4'd0;
        for (int c = 0; c < 5; c++) begin
            cmp_val = 16'(c);
            restart();
            for (int n = 1; n <= 15; n++) begin
                step(1);
                chk("R3 match clear", local_time, 16'(n % (c + 1)));
            end
        end

        // R4: free-running wrap
        clr_on_match = 1'b0; cmp_val = 16'hFFFF; mode = 3'b111;
        restart();
        bus_write(2'd0, 16'hFFFE);
        chk("R4 loaded", local_time, 16'hFFFE);
        step(1);
        chk("R4 top", local_time, 16'hFFFF);
        step(1);
        chk("R4 wrap", local_time, 16'h0000);
        step(1);
        chk("R4 after wrap", local_time, 16'h0001);

        // R5: writes only in mode 3'b111 (no tick within the window)
        presc_div = 4'd15;
        for (int m = 0; m < 8; m++) begin
            mode = m[2:0];
            restart();
            bus_write(2'd0, 16'h0A00 + 16'(m));
            bus_read(2'd0, rd);
            chk("R5 mode write gate", rd, (m == 7) ? 16'h0A00 + 16'(m) : 16'h0000);
        end

        // R6: capture and modular cycle time
        mode = 3'd0; presc_div = 4'd0;
        restart();
        step(5);
        ref_capture = 1'b1;
        step(1);
        ref_capture = 1'b0;
        chk("R6 local", local_time, 16'd6);
        chk("R6 cycle after capture", cycle_time, 16'd1);
        step(10);
        chk("R6 cycle later", cycle_time, 16'd11);
        bus_read(2'd1, rd);
        chk("R6 bus cycle time", rd, 16'd11);
        restart();
        step(2);
        chk("R6 negative difference", cycle_time, 16'hFFFD);

        // R7: event mode ignores capture, mark zero
        mode = 3'b111;
        #1 chk("R7 immediate copy", cycle_time, local_time);
        ref_capture = 1'b1;
        step(1);
        ref_capture = 1'b0;
        step(3);
        chk("R7 copy after capture", cycle_time, local_time);
        mode = 3'd0;
        #1 chk("R7 mark stays zero", cycle_time, local_time);

        // R8: base-cycle sweep
        for (int mx = 0; mx < 5; mx++) begin
            max_cycle = 6'(mx);
            restart();
            for (int k = 1; k <= 10; k++) begin
                cycle_adv = 1'b1;
                step(1);
                chk("R8 base cycle", {10'd0, base_cycle}, 16'(k % (mx + 1)));
            end
            cycle_adv = 1'b0;
            step(2);
            chk("R8 hold", {10'd0, base_cycle}, 16'(10 % (mx + 1)));
        end
        tmr_en = 1'b0;
        step(1);
        chk("R8 disable clears", {10'd0, base_cycle}, 16'h0000);

        // R9: read-only registers
        max_cycle = 6'd40; presc_div = 4'd15; mode = 3'b111;
        restart();
        cycle_adv = 1'b1;
        step(3);
        cycle_adv = 1'b0;
        held = local_time;
        bus_write(2'd2, 16'hFFFF);
        bus_write(2'd1, 16'hFFFF);
        bus_read(2'd2, rd);
        chk("R9 base read", rd, 16'h0003);
        chk("R9 upper zero", {rd[15:6], 6'd0}, 16'h0000);
        chk("R9 time untouched", local_time, held);

        // R10: write beats compare clear
        clr_on_match = 1'b1; cmp_val = 16'd3; presc_div = 4'd0;
        restart();
        step(3);
        chk("R10 at match", local_time, 16'd3);
        bus_write(2'd0, 16'h0100);
        chk("R10 write wins", local_time, 16'h0100);
        step(1);
        chk("R10 continues", local_time, 16'h0101);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule